// File: doc/BRIEF.md
# Three-Operand Multiply-Accumulate Execution Unit

This unit executes one class of integer instructions: multiply with accumulate or subtract, in a 32-bit form, a 64-bit form and widening forms that start from 32-bit sources. It also returns the upper 64 bits of a full signed or unsigned 64-by-64 product. A 32-bit instruction word arrives together with three 64-bit source values named n, m and a. An external register file reads these values. The unit sends back the result, the destination register index and a flag for illegal encodings.

Seven bits scattered across the instruction word are packed into one operation code, and that code selects the mode. The input is a valid/ready stream. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while an operation is in flight, which is the back-pressure. The sender must then hold its word and operands stable until a later edge accepts them. The output side has no ready signal. Completion is a single-cycle pulse on `out_valid`, and the output registers keep their values until the next completion.

Top module: `mac3_exec`

## Requirements
- R1: `in_ready` is high whenever no operation is in flight. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. After that edge `in_ready` stays low until the result pulse.
- R2: `out_valid` rises on the second rising edge after the accepting edge and stays high for exactly one cycle. `out_result`, `out_rd`, `out_wen` and `out_illegal` keep their values until the next completion.
- R3: The operation code is {bit 31, bits 30:29, bits 23:21, bit 15} of the word. Bits 28:24 must equal 11011. `out_rd` carries bits 4:0 of the word that was accepted.
- R4: Code 0x40 returns a + n*m and code 0x41 returns a - n*m, both wrapping modulo 2^64.
- R5: Codes 0x00 and 0x01 do the same as R4, but bits 63:32 of the result are forced to zero.
- R6: Codes 0x42 and 0x43 sign-extend the low 32 bits of n and m to 64 bits. They then return a + product or a - product modulo 2^64.
- R7: Codes 0x4A and 0x4B do the same as R6 with zero extension.
- R8: Code 0x44 returns bits 127:64 of the signed 128-bit product of n and m. The a operand has no effect on this result.
- R9: Code 0x4C returns bits 127:64 of the unsigned 128-bit product of n and m. The a operand has no effect on this result.
- R10: Any other code is illegal, and so is a fixed-field mismatch. An illegal word completes with `out_illegal`=1, `out_wen`=0 and `out_result`=0. A legal word completes with `out_illegal`=0 and `out_wen`=1.
- R11: During and right after reset, `in_ready`=1, `out_valid`=0, `out_wen`=0, `out_illegal`=0 and `out_result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word and operands are presented |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_insn | input | 32 | Instruction word |
| in_n | input | 64 | First multiplicand |
| in_m | input | 64 | Second multiplicand |
| in_a | input | 64 | Accumulator operand |
| out_valid | output | 1 | One-cycle completion pulse |
| out_wen | output | 1 | Destination write enable accompanying the pulse |
| out_illegal | output | 1 | Word was not an allocated encoding |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Result value |

## Verification
The assertions check the stream rules on every cycle: `in_ready` drops after an accept, the completion pulse lasts one cycle and arrives at a fixed distance after the accept, and outputs stay stable between completions. On the same basis they check that narrow results have a zero upper half and that illegal words return zero. Numerical correctness is shown only by the bench's scenarios. Each allocated code runs against a 128-bit reference model over corner operands: zero, all-ones, the most negative 64-bit value and the most negative 32-bit value. The bench also shows that a has no effect on the high-product codes, and it shows back-to-back issue under back-pressure.

// File: rtl/mac3_pkg.sv
package mac3_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 7;
  localparam int unsigned RIDX_W  = 5;
  localparam logic [4:0]  CLASS_TAG = 5'b11011;

  typedef enum logic [OPC_W-1:0] {
    OPC_MACC_W  = 7'h00,
    OPC_MSUB_W  = 7'h01,
    OPC_MACC_X  = 7'h40,
    OPC_MSUB_X  = 7'h41,
    OPC_SWACC   = 7'h42,
    OPC_SWSUB   = 7'h43,
    OPC_SHIGH   = 7'h44,
    OPC_UWACC   = 7'h4A,
    OPC_UWSUB   = 7'h4B,
    OPC_UHIGH   = 7'h4C
  } opc_e;

  typedef struct packed {
    logic legal;
    logic sub;
    logic high;
    logic sgn;
    logic widen;
    logic narrow;
  } mac_ctl_t;
endpackage

// File: rtl/mac3_decode.sv
module mac3_decode
  import mac3_pkg::*;
(
  input  logic [10:0]    hdr,     // word bits 31:21
  input  logic           o0,      // word bit 15
  output mac_ctl_t       ctl
);
  logic [OPC_W-1:0] opc;
  logic             tag_ok;

  assign opc    = {hdr[10], hdr[9:8], hdr[2:0], o0};
  assign tag_ok = (hdr[7:3] == CLASS_TAG);

  always_comb begin
    ctl        = '0;
    ctl.sub    = opc[0];
    ctl.high   = opc[2];
    ctl.narrow = ~opc[6];
    unique case (opc)
      OPC_MACC_W, OPC_MSUB_W, OPC_MACC_X, OPC_MSUB_X: ctl.legal = tag_ok;
      OPC_SWACC, OPC_SWSUB: begin
        ctl.legal = tag_ok;
        ctl.sgn   = 1'b1;
        ctl.widen = 1'b1;
      end
      OPC_SHIGH: begin
        ctl.legal = tag_ok;
        ctl.sgn   = 1'b1;
      end
      OPC_UWACC, OPC_UWSUB: begin
        ctl.legal = tag_ok;
        ctl.widen = 1'b1;
      end
      OPC_UHIGH: ctl.legal = tag_ok;
      default:   ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac3_datapath.sv
module mac3_datapath
  import mac3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  mac_ctl_t          ctl,
  input  logic [XLEN-1:0]   src_n,
  input  logic [XLEN-1:0]   src_m,
  input  logic [XLEN-1:0]   src_a,
  output logic [XLEN-1:0]   res
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned PW   = 2 * XLEN;

  logic [XLEN-1:0] opn, opm, low, acc, hi_u, hi_s;
  logic [PW-1:0]   prod;

  // Condition both multiplicands the same way; widening narrows to HALF bits.
  always_comb begin
    opn = src_n;
    opm = src_m;
    if (ctl.widen) begin
      opn = ctl.sgn ? {{HALF{src_n[HALF-1]}}, src_n[HALF-1:0]}
                    : {{HALF{1'b0}}, src_n[HALF-1:0]};
      opm = ctl.sgn ? {{HALF{src_m[HALF-1]}}, src_m[HALF-1:0]}
                    : {{HALF{1'b0}}, src_m[HALF-1:0]};
    end
  end

  // One shared unsigned full-width multiplier.
  assign prod = {{XLEN{1'b0}}, opn} * {{XLEN{1'b0}}, opm};
  assign low  = prod[XLEN-1:0];
  assign hi_u = prod[PW-1:XLEN];
  // Signed upper half from unsigned upper half by subtracting the cross terms.
  assign hi_s = hi_u - (src_n[XLEN-1] ? src_m : '0) - (src_m[XLEN-1] ? src_n : '0);

  assign acc = ctl.sub ? (src_a - low) : (src_a + low);

  always_comb begin
    if (!ctl.legal)    res = '0;
    else if (ctl.high) res = ctl.sgn ? hi_s : hi_u;
    else if (ctl.narrow) res = {{HALF{1'b0}}, acc[HALF-1:0]};
    else               res = acc;
  end
endmodule

// File: rtl/mac3_exec.sv
module mac3_exec
  import mac3_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_insn,
  input  logic [XLEN-1:0]   in_n,
  input  logic [XLEN-1:0]   in_m,
  input  logic [XLEN-1:0]   in_a,
  output logic              out_valid,
  output logic              out_wen,
  output logic              out_illegal,
  output logic [4:0]        out_rd,
  output logic [XLEN-1:0]   out_result
);
  localparam int unsigned HALF = XLEN / 2;

  mac_ctl_t          ctl_d, ctl_q;
  logic              busy_q;
  logic              accept;
  logic [XLEN-1:0]   n_q, m_q, a_q, dp_res;
  logic [RIDX_W-1:0] rd_q;

  assign in_ready = ~busy_q;
  assign accept   = in_valid & in_ready;

  mac3_decode u_dec (
    .hdr (in_insn[31:21]),
    .o0  (in_insn[15]),
    .ctl (ctl_d)
  );

  mac3_datapath #(.XLEN(XLEN)) u_dp (
    .ctl   (ctl_q),
    .src_n (n_q),
    .src_m (m_q),
    .src_a (a_q),
    .res   (dp_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ctl_q  <= '0;
      n_q    <= '0;
      m_q    <= '0;
      a_q    <= '0;
      rd_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ctl_q  <= ctl_d;
      n_q    <= in_n;
      m_q    <= in_m;
      a_q    <= in_a;
      rd_q   <= in_insn[4:0];
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
    end else begin
      out_valid <= busy_q;
      if (busy_q) begin
        out_wen     <= ctl_q.legal;
        out_illegal <= ~ctl_q.legal;
        out_rd      <= rd_q;
        out_result  <= dp_res;
      end
    end
  end

  // R1
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 out_valid);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));
  // R5
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctl_q.narrow) |=> (out_result[XLEN-1:HALF] == '0));
  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));
endmodule

// File: tb/mac3_exec_tb_top.sv
module mac3_exec_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [63:0] in_n = '0, in_m = '0, in_a = '0;
  logic        out_valid, out_wen, out_illegal;
  logic [4:0]  out_rd;
  logic [63:0] out_result;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac3_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_n(in_n), .in_m(in_m), .in_a(in_a),
    .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_result(out_result)
  );

  logic [63:0] corners [6];
  initial begin
    corners[0] = 64'h0;
    corners[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[2] = 64'h8000_0000_0000_0000;
    corners[3] = 64'h0000_0000_8000_0000;
    corners[4] = 64'h0123_4567_89AB_CDEF;
    corners[5] = 64'hFEDC_BA98_7654_3211;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] opc, input logic [4:0] rd,
                                     input logic [4:0] tag);
    return {opc[6], opc[5:4], tag, opc[3:1], 5'd3, opc[0], 5'd7, 5'd9, rd};
  endfunction

  // Reference model using 128-bit arithmetic.
  task automatic ref_model(input logic [6:0] opc, input logic [63:0] n, m, a,
                           output logic ill, output logic [63:0] r);
    logic [127:0] w;
    logic [63:0]  p;
    ill = 1'b0;
    r   = '0;
    case (opc)
      7'h00, 7'h01, 7'h40, 7'h41: begin
        p = n * m;
        r = opc[0] ? a - p : a + p;
        if (!opc[6]) r[63:32] = '0;
      end
      7'h42, 7'h43: begin
        w = {{96{n[31]}}, n[31:0]} * {{96{m[31]}}, m[31:0]};
        r = opc[0] ? a - w[63:0] : a + w[63:0];
      end
      7'h4A, 7'h4B: begin
        w = {96'b0, n[31:0]} * {96'b0, m[31:0]};
        r = opc[0] ? a - w[63:0] : a + w[63:0];
      end
      7'h44: begin
        w = {{64{n[63]}}, n} * {{64{m[63]}}, m};
        r = w[127:64];
      end
      7'h4C: begin
        w = {64'b0, n} * {64'b0, m};
        r = w[127:64];
      end
      default: ill = 1'b1;
    endcase
  endtask

  // Issue one word, check handshake timing, return outputs at the pulse.
  task automatic issue(input logic [31:0] insn, input logic [63:0] n, m, a,
                       output logic [63:0] res, output logic ill, output logic wen);
    int waits;
    @(negedge clk);
    in_insn = insn; in_n = n; in_m = m; in_a = a; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 ready low after accept", {63'b0, in_ready}, 64'd0);
    waits = 0;
    while (!out_valid && waits < 20) begin
      @(negedge clk);
      waits++;
    end
    chk("R2 latency", waits, 1);
    chk("R3 rd", {59'b0, out_rd}, {59'b0, insn[4:0]});
    res = out_result; ill = out_illegal; wen = out_wen;
    @(negedge clk);
    chk("R2 pulse one cycle", {63'b0, out_valid}, 64'd0);
    chk("R2 result held", out_result, res);
  endtask

  task automatic run_code(input logic [6:0] opc, input string tag);
    logic [63:0] res, exp;
    logic ill, wen, eill;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        ref_model(opc, corners[i], corners[j], corners[(i + j + 1) % 6], eill, exp);
        issue(mk(opc, 5'(i * 6 + j), 5'b11011), corners[i], corners[j],
              corners[(i + j + 1) % 6], res, ill, wen);
        chk(tag, res, exp);
        chk({tag, " wen"}, {63'b0, wen}, 64'd1);
        chk("R10 legal flag", {63'b0, ill}, 64'd0);
      end
    end
  endtask

  task automatic test_reset;
    chk("R11 ready", {63'b0, in_ready}, 64'd1);
    chk("R11 valid", {63'b0, out_valid}, 64'd0);
    chk("R11 wen", {63'b0, out_wen}, 64'd0);
    chk("R11 illegal", {63'b0, out_illegal}, 64'd0);
    chk("R11 result", out_result, 64'd0);
  endtask

  task automatic test_wrap64;
    run_code(7'h40, "R4 add64");
    run_code(7'h41, "R4 sub64");
  endtask

  task automatic test_narrow;
    run_code(7'h00, "R5 add32");
    run_code(7'h01, "R5 sub32");
  endtask

  task automatic test_swiden;
    run_code(7'h42, "R6 sadd");
    run_code(7'h43, "R6 ssub");
  endtask

  task automatic test_uwiden;
    run_code(7'h4A, "R7 uadd");
    run_code(7'h4B, "R7 usub");
  endtask

  task automatic test_high;
    logic [63:0] r1, r2, exp;
    logic ill, wen, eill;
    run_code(7'h44, "R8 shigh");
    run_code(7'h4C, "R9 uhigh");
    // a must not matter
    ref_model(7'h44, corners[2], corners[5], 64'd0, eill, exp);
    issue(mk(7'h44, 5'd1, 5'b11011), corners[2], corners[5], 64'd0, r1, ill, wen);
    issue(mk(7'h44, 5'd1, 5'b11011), corners[2], corners[5], corners[1], r2, ill, wen);
    chk("R8 a ignored", r2, r1);
    chk("R8 value", r1, exp);
    issue(mk(7'h4C, 5'd2, 5'b11011), corners[1], corners[1], 64'd0, r1, ill, wen);
    issue(mk(7'h4C, 5'd2, 5'b11011), corners[1], corners[1], corners[4], r2, ill, wen);
    chk("R9 a ignored", r2, r1);
    chk("R9 value", r1, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic test_illegal;
    logic [6:0] bad_codes [6];
    logic [63:0] res;
    logic ill, wen;
    bad_codes[0] = 7'h02; bad_codes[1] = 7'h04; bad_codes[2] = 7'h20;
    bad_codes[3] = 7'h45; bad_codes[4] = 7'h4D; bad_codes[5] = 7'h7F;
    for (int k = 0; k < 6; k++) begin
      issue(mk(bad_codes[k], 5'd17, 5'b11011), corners[4], corners[5], corners[1], res, ill, wen);
      chk("R10 illegal flag", {63'b0, ill}, 64'd1);
      chk("R10 no write", {63'b0, wen}, 64'd0);
      chk("R10 zero result", res, 64'd0);
    end
    issue(mk(7'h40, 5'd4, 5'b11010), corners[4], corners[5], corners[1], res, ill, wen);
    chk("R3 tag mismatch flag", {63'b0, ill}, 64'd1);
    chk("R10 tag mismatch no write", {63'b0, wen}, 64'd0);
  endtask

  task automatic test_backpressure;
    logic [63:0] ra;
    @(negedge clk);
    in_insn = mk(7'h40, 5'd5, 5'b11011); in_n = 64'd3; in_m = 64'd4; in_a = 64'd5;
    in_valid = 1'b1;
    @(negedge clk);                      // A accepted
    in_insn = mk(7'h41, 5'd6, 5'b11011); in_n = 64'd2; in_m = 64'd10; in_a = 64'd1;
    chk("R1 busy blocks", {63'b0, in_ready}, 64'd0);
    @(negedge clk);                      // A completes
    chk("R2 first pulse", {63'b0, out_valid}, 64'd1);
    chk("R4 first result", out_result, 64'd17);
    chk("R1 ready again", {63'b0, in_ready}, 64'd1);
    ra = out_result;
    @(negedge clk);                      // B accepted
    in_valid = 1'b0;
    chk("R1 second accepted", {63'b0, in_ready}, 64'd0);
    chk("R2 held while busy", out_result, ra);
    @(negedge clk);
    chk("R2 second pulse", {63'b0, out_valid}, 64'd1);
    chk("R4 second result", out_result, 64'hFFFF_FFFF_FFFF_FFED);
    chk("R3 second rd", {59'b0, out_rd}, 64'd6);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_wrap64();
    test_narrow();
    test_swiden();
    test_uwiden();
    test_high();
    test_illegal();
    test_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule